// File: doc/BRIEF.md
# Blocking Directory Home Controller

This block is the home-node controller of a small multicore system. It sits beside the shared last-level cache and holds one directory entry for every block. An entry records the stable state (Idle, Shared or Modified), the owning core, and a sharer bit vector with one bit per core. The private caches send request messages on a point-to-point port: load miss, upgrade miss, unblock and writeback. One message a cycle leaves on the output port. It is a data response, a load forward, an invalidate or a bare write grant. The message names its destination cores as a bit mask and also carries the original requester.

The protocol is blocking. Any load or upgrade opens a transaction and marks the entry blocked. The entry stays blocked until the requester returns an unblock for that line. A load miss to a line with no cached copies is granted Exclusive; the directory then tracks that core as the owner. A load to an owned line goes to the owner, which supplies the data, and the later unblock writes that data back into the shared cache. Requests that reach a blocked line wait in a small parking queue and are retried oldest first once the line unblocks. Requests to other lines go ahead in the meantime.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset `msg_valid` is 0, `req_ready` is 1, every line is Idle and every line of the shared cache holds zero.
- R2: A load miss (`req_kind` 0) to an Idle line produces, one cycle after acceptance, a data response (`msg_kind` 0) to the requester alone. It carries the shared-cache data, `msg_excl`=1 and `msg_acks`=0. The requester's unblock makes it the owner.
- R3: A load miss to a Shared line produces a data response with `msg_excl`=0 and `msg_acks`=0. The requester's unblock adds it to the sharers.
- R4: A load miss to an owned line produces a load forward (`msg_kind` 1) to the owner with `msg_requester` set to the requester. The unblock (`req_kind` 2) with `req_dirty`=1 writes `req_data` into the shared cache. The line becomes Shared with both the old owner and the requester as sharers.
- R5: An upgrade miss (`req_kind` 1) from a sharer of a Shared line produces an invalidate (`msg_kind` 2) to every other sharer, with `msg_acks` equal to their number. An upgrade from the owner of an owned line produces a write grant (`msg_kind` 3) with `msg_acks`=0. After the unblock the requester is the sole owner.
- R6: An upgrade from a core that is not a sharer of a Shared line sends the invalidate to the sharers and to the requester as well, carrying the shared-cache data, with `msg_acks` counting only the others. An upgrade to an Idle line gets an exclusive data response. An upgrade to a line owned by another core gets a load forward with `msg_excl`=1.
- R7: A load, upgrade or writeback to a blocked line is parked with no message. After that line unblocks, parked requests are served oldest first. Requests to other lines are served while others wait.
- R8: An unblock produces no message. It is ignored unless it comes from the pending requester of a blocked line.
- R9: A writeback (`req_kind` 3) from the owner returns the line to Idle, and writes `req_data` into the shared cache only when `req_dirty`=1. A writeback from any other core is ignored. A writeback produces no message.
- R10: While the parking queue is full and no parked request is ready, `req_ready` is 0 for loads, upgrades and writebacks and 1 for unblocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | 0 load miss, 1 upgrade miss, 2 unblock, 3 writeback |
| req_src | input | $clog2(NCORES) | Sending core |
| req_line | input | $clog2(NLINES) | Block index |
| req_dirty | input | 1 | Message carries modified data |
| req_data | input | DW | Block data |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 data, 1 load forward, 2 invalidate, 3 write grant |
| msg_dst | output | NCORES | Destination core mask |
| msg_requester | output | $clog2(NCORES) | Core that opened the transaction |
| msg_line | output | $clog2(NLINES) | Block index |
| msg_acks | output | $clog2(NCORES+1) | Acknowledgements the requester must collect |
| msg_excl | output | 1 | Exclusive grant or forward for write |
| msg_data | output | DW | Shared-cache data |

## Verification
The bench builds the block with four cores, four lines, 16-bit data and a two-entry parking queue. Four cores give a three-sharer line, so the invalidate mask and ack count of both upgrade forms are non-trivial. The two-slot queue can be filled by two requests held behind one line. That reaches the full-queue case where only an unblock is accepted, and it shows that parked requests are retried in arrival order.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NCORES = 4,
  parameter int NLINES = 16,
  parameter int DW     = 32,
  parameter int QDEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_kind,
  input  logic [$clog2(NCORES)-1:0]   req_src,
  input  logic [$clog2(NLINES)-1:0]   req_line,
  input  logic                        req_dirty,
  input  logic [DW-1:0]               req_data,
  output logic                        msg_valid,
  output logic [1:0]                  msg_kind,
  output logic [NCORES-1:0]           msg_dst,
  output logic [$clog2(NCORES)-1:0]   msg_requester,
  output logic [$clog2(NLINES)-1:0]   msg_line,
  output logic [$clog2(NCORES+1)-1:0] msg_acks,
  output logic                        msg_excl,
  output logic [DW-1:0]               msg_data
);
  localparam int CW = $clog2(NCORES);
  localparam int LW = $clog2(NLINES);
  localparam int AW = $clog2(NCORES+1);
  localparam int QW = $clog2(QDEPTH+1);
  localparam int QI = $clog2(QDEPTH);

  localparam logic [1:0] K_LD = 2'd0, K_UPG = 2'd1, K_UNB = 2'd2, K_WB = 2'd3;
  localparam logic [1:0] M_DATA = 2'd0, M_FWD = 2'd1, M_INV = 2'd2, M_GNT = 2'd3;
  localparam logic [1:0] P_OWN = 2'd0, P_ADD = 2'd1, P_FWD = 2'd2;

  typedef enum logic [1:0] {D_IDLE, D_SHR, D_MOD} dstate_t;

  dstate_t           st   [NLINES];
  logic [CW-1:0]     own  [NLINES];
  logic [NCORES-1:0] shr  [NLINES];
  logic [1:0]        pk   [NLINES];
  logic [CW-1:0]     pq   [NLINES];
  logic [DW-1:0]     llc  [NLINES];
  logic [NLINES-1:0] blk;

  logic [1:0]    q_kind  [QDEPTH];
  logic [CW-1:0] q_src   [QDEPTH];
  logic [LW-1:0] q_line  [QDEPTH];
  logic          q_dirty [QDEPTH];
  logic [DW-1:0] q_data  [QDEPTH];
  logic [QW-1:0] q_cnt;

  logic          q_hit;
  logic [QI-1:0] q_sel;

  always_comb begin
    q_hit = 1'b0;
    q_sel = '0;
    for (int i = QDEPTH-1; i >= 0; i--)
      if (QW'(i) < q_cnt && !blk[q_line[i]]) begin
        q_hit = 1'b1;
        q_sel = QI'(i);
      end
  end

  wire q_full  = (q_cnt == QW'(QDEPTH));
  assign req_ready = !q_hit && (!q_full || req_kind == K_UNB);
  wire in_fire = req_valid && req_ready;
  wire in_park = in_fire && req_kind != K_UNB && blk[req_line];
  wire c_go    = q_hit || (in_fire && !in_park);

  wire [1:0]    c_kind  = q_hit ? q_kind[q_sel]  : req_kind;
  wire [CW-1:0] c_src   = q_hit ? q_src[q_sel]   : req_src;
  wire [LW-1:0] c_line  = q_hit ? q_line[q_sel]  : req_line;
  wire          c_dirty = q_hit ? q_dirty[q_sel] : req_dirty;
  wire [DW-1:0] c_data  = q_hit ? q_data[q_sel]  : req_data;

  wire [NCORES-1:0] c_bit    = NCORES'(1) << c_src;
  wire [NCORES-1:0] c_ownbit = NCORES'(1) << own[c_line];
  wire [NCORES-1:0] c_others = shr[c_line] & ~c_bit;
  wire              c_in_shr = shr[c_line][c_src];
  wire [AW-1:0]     c_ocnt   = AW'($countones(c_others));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid     <= 1'b0;
      msg_kind      <= M_DATA;
      msg_dst       <= '0;
      msg_requester <= '0;
      msg_line      <= '0;
      msg_acks      <= '0;
      msg_excl      <= 1'b0;
      msg_data      <= '0;
      blk           <= '0;
      q_cnt         <= '0;
      for (int l = 0; l < NLINES; l++) begin
        st[l]  <= D_IDLE;
        own[l] <= '0;
        shr[l] <= '0;
        pk[l]  <= P_OWN;
        pq[l]  <= '0;
        llc[l] <= '0;
      end
      for (int i = 0; i < QDEPTH; i++) begin
        q_kind[i]  <= K_LD;
        q_src[i]   <= '0;
        q_line[i]  <= '0;
        q_dirty[i] <= 1'b0;
        q_data[i]  <= '0;
      end
    end else begin
      msg_valid <= 1'b0;

      if (in_park) begin
        for (int i = 0; i < QDEPTH; i++)
          if (QW'(i) == q_cnt) begin
            q_kind[i]  <= req_kind;
            q_src[i]   <= req_src;
            q_line[i]  <= req_line;
            q_dirty[i] <= req_dirty;
            q_data[i]  <= req_data;
          end
        q_cnt <= q_cnt + 1'b1;
      end else if (q_hit) begin
        for (int i = 0; i < QDEPTH-1; i++)
          if (QI'(i) >= q_sel) begin
            q_kind[i]  <= q_kind[i+1];
            q_src[i]   <= q_src[i+1];
            q_line[i]  <= q_line[i+1];
            q_dirty[i] <= q_dirty[i+1];
            q_data[i]  <= q_data[i+1];
          end
        q_cnt <= q_cnt - 1'b1;
      end

      if (c_go) begin
        msg_requester <= c_src;
        msg_line      <= c_line;
        msg_data      <= llc[c_line];
        msg_acks      <= '0;
        msg_excl      <= 1'b0;
        msg_dst       <= c_bit;
        msg_kind      <= M_DATA;
        case (c_kind)
          K_LD: begin
            blk[c_line] <= 1'b1;
            pq[c_line]  <= c_src;
            msg_valid   <= 1'b1;
            case (st[c_line])
              D_MOD: begin
                msg_kind   <= M_FWD;
                msg_dst    <= c_ownbit;
                pk[c_line] <= P_FWD;
              end
              D_SHR: pk[c_line] <= P_ADD;
              default: begin
                msg_excl   <= 1'b1;
                pk[c_line] <= P_OWN;
              end
            endcase
          end
          K_UPG: begin
            blk[c_line] <= 1'b1;
            pq[c_line]  <= c_src;
            pk[c_line]  <= P_OWN;
            msg_valid   <= 1'b1;
            case (st[c_line])
              D_SHR: begin
                if (c_others == '0 && c_in_shr) begin
                  msg_kind <= M_GNT;
                end else begin
                  msg_kind <= M_INV;
                  msg_dst  <= c_others | (c_in_shr ? '0 : c_bit);
                  msg_acks <= c_ocnt;
                end
              end
              D_MOD: begin
                if (own[c_line] == c_src) begin
                  msg_kind <= M_GNT;
                end else begin
                  msg_kind <= M_FWD;
                  msg_dst  <= c_ownbit;
                  msg_excl <= 1'b1;
                end
              end
              default: msg_excl <= 1'b1;
            endcase
          end
          K_UNB: begin
            if (blk[c_line] && pq[c_line] == c_src) begin
              blk[c_line] <= 1'b0;
              case (pk[c_line])
                P_ADD: begin
                  st[c_line]  <= D_SHR;
                  shr[c_line] <= shr[c_line] | c_bit;
                end
                P_FWD: begin
                  st[c_line]  <= D_SHR;
                  shr[c_line] <= c_bit | c_ownbit;
                  if (c_dirty) llc[c_line] <= c_data;
                end
                default: begin
                  st[c_line]  <= D_MOD;
                  own[c_line] <= c_src;
                  shr[c_line] <= c_bit;
                end
              endcase
            end
          end
          default: begin
            if (st[c_line] == D_MOD && own[c_line] == c_src) begin
              st[c_line]  <= D_IDLE;
              shr[c_line] <= '0;
              own[c_line] <= '0;
              if (c_dirty) llc[c_line] <= c_data;
            end
          end
        endcase
      end
    end
  end

  assert_fwd_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == M_FWD) |-> $countones(msg_dst) == 1);

  assert_reply_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_kind == M_DATA || msg_kind == M_GNT))
      |-> (msg_dst == (NCORES'(1) << msg_requester) && msg_acks == '0));

  assert_inval_ack_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == M_INV)
      |-> (msg_dst != '0 &&
           msg_acks == AW'($countones(msg_dst & ~(NCORES'(1) << msg_requester)))));

  assert_unblock_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && req_kind == K_UNB) |=> !msg_valid);

  assert_writeback_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && req_kind == K_WB && !in_park) |=> !msg_valid);

  assert_park_grows_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_park |=> (q_cnt == $past(q_cnt) + 1'b1 && !msg_valid));

  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QW'(QDEPTH));
endmodule

// File: tb/tb_dir_home_ctrl.sv
`timescale 1ns/1ps
module tb_dir_home_ctrl;
  localparam int NC = 4, NL = 4, DW = 16, QD = 2;
  localparam int CW = $clog2(NC), LW = $clog2(NL), AW = $clog2(NC+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_dirty = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = '0;
  logic [CW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic [DW-1:0] req_data = '0;
  logic msg_valid, msg_excl;
  logic [1:0] msg_kind;
  logic [NC-1:0] msg_dst;
  logic [CW-1:0] msg_requester;
  logic [LW-1:0] msg_line;
  logic [AW-1:0] msg_acks;
  logic [DW-1:0] msg_data;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.NCORES(NC), .NLINES(NL), .DW(DW), .QDEPTH(QD)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_line(req_line),
    .req_dirty(req_dirty), .req_data(req_data), .msg_valid(msg_valid),
    .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_requester(msg_requester),
    .msg_line(msg_line), .msg_acks(msg_acks), .msg_excl(msg_excl),
    .msg_data(msg_data));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(int k, int s, int l, int d, int dat);
    @(negedge clk);
    req_kind = 2'(k); req_src = CW'(s); req_line = LW'(l);
    req_dirty = d[0]; req_data = DW'(dat); req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_msg(string tag, int kind, int dst, int rq, int acks, int excl, int dat);
    chk({tag, " valid"}, int'(msg_valid), 1);
    chk({tag, " kind"}, int'(msg_kind), kind);
    chk({tag, " dst"}, int'(msg_dst), dst);
    chk({tag, " requester"}, int'(msg_requester), rq);
    chk({tag, " acks"}, int'(msg_acks), acks);
    chk({tag, " excl"}, int'(msg_excl), excl);
    chk({tag, " data"}, int'(msg_data), dat);
  endtask

  task automatic expect_quiet(string tag);
    chk({tag, " no message"}, int'(msg_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 msg_valid after reset", int'(msg_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_line0_flow;
    send(0, 1, 0, 0, 0);  expect_msg("R2 load idle", 0, 4'b0010, 1, 0, 1, 0);
    send(2, 1, 0, 0, 0);  expect_quiet("R8 unblock");
    send(0, 2, 0, 0, 0);  expect_msg("R4 forward to owner", 1, 4'b0010, 2, 0, 0, 0);
    send(2, 2, 0, 1, 16'h1234); expect_quiet("R8 unblock fwd");
    send(0, 3, 0, 0, 0);  expect_msg("R4 R3 load shared gets written data", 0, 4'b1000, 3, 0, 0, 16'h1234);
    send(2, 3, 0, 0, 0);
    send(1, 1, 0, 0, 0);  expect_msg("R5 R3 invalidate others", 2, 4'b1100, 1, 2, 0, 16'h1234);
    send(2, 1, 0, 0, 0);
    send(0, 0, 0, 0, 0);  expect_msg("R5 sole owner after upgrade", 1, 4'b0010, 0, 0, 0, 16'h1234);
    send(2, 0, 0, 0, 0);
  endtask

  task automatic t_writeback;
    send(0, 0, 1, 0, 0);  expect_msg("R2 load idle line1", 0, 4'b0001, 0, 0, 1, 0);
    send(2, 0, 1, 0, 0);
    send(3, 0, 1, 1, 16'hBEEF); expect_quiet("R9 writeback");
    send(0, 2, 1, 0, 0);  expect_msg("R9 idle after writeback", 0, 4'b0100, 2, 0, 1, 16'hBEEF);
    send(2, 2, 1, 0, 0);
    send(3, 3, 1, 1, 16'h5555); expect_quiet("R9 stale writeback");
    send(0, 1, 1, 0, 0);  expect_msg("R9 stale writeback keeps owner", 1, 4'b0100, 1, 0, 0, 16'hBEEF);
    send(2, 1, 1, 0, 0);
    send(0, 3, 1, 0, 0);  expect_msg("R9 stale data not written", 0, 4'b1000, 3, 0, 0, 16'hBEEF);
    send(2, 3, 1, 0, 0);
  endtask

  task automatic t_blocking;
    send(0, 0, 2, 0, 0);  expect_msg("R2 load idle line2", 0, 4'b0001, 0, 0, 1, 0);
    send(2, 3, 2, 0, 0);  expect_quiet("R8 wrong unblock");
    send(0, 1, 2, 0, 0);  expect_quiet("R7 R8 parked while still blocked");
    send(0, 2, 3, 0, 0);  expect_msg("R7 other line served", 0, 4'b0100, 2, 0, 1, 0);
    send(2, 2, 3, 0, 0);
    send(2, 0, 2, 0, 0);  expect_quiet("R8 real unblock");
    @(negedge clk);
    expect_msg("R7 parked load retried", 1, 4'b0001, 1, 0, 0, 0);
  endtask

  task automatic t_queue_full;
    send(0, 3, 2, 0, 0);  expect_quiet("R7 park first");
    send(1, 2, 2, 0, 0);  expect_quiet("R7 park second");
    @(negedge clk);
    req_kind = 2'd0; req_src = '0; req_line = '0; req_dirty = 1'b0; req_valid = 1'b1;
    #1 chk("R10 load refused when full", int'(req_ready), 0);
    req_kind = 2'd2; req_src = CW'(1); req_line = LW'(2); req_dirty = 1'b1; req_data = 16'h7777;
    #1 chk("R10 unblock accepted when full", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_quiet("R10 unblock");
    @(negedge clk);
    expect_msg("R7 oldest parked first", 0, 4'b1000, 3, 0, 0, 16'h7777);
    send(2, 3, 2, 0, 0);
    @(negedge clk);
    expect_msg("R6 upgrade from non-sharer", 2, 4'b1111, 2, 3, 0, 16'h7777);
    send(2, 2, 2, 0, 0);
  endtask

  task automatic t_upgrade_forms;
    send(1, 0, 3, 0, 0);  expect_msg("R6 upgrade to owned line", 1, 4'b0100, 0, 0, 1, 0);
    send(2, 0, 3, 0, 0);
    send(3, 0, 3, 0, 16'h9999); expect_quiet("R9 clean writeback");
    send(1, 1, 3, 0, 0);  expect_msg("R6 R9 upgrade to idle line", 0, 4'b0010, 1, 0, 1, 0);
    send(2, 1, 3, 0, 0);
    send(1, 1, 3, 0, 0);  expect_msg("R5 owner upgrade grant", 3, 4'b0010, 1, 0, 0, 0);
    send(2, 1, 3, 0, 0);
  endtask

  initial begin
    #(5.0 * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_line0_flow;
    t_writeback;
    t_blocking;
    t_queue_full;
    t_upgrade_forms;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule